// File: doc/BRIEF.md
# Convolution Layer Dot-Product Engine

The engine evaluates one 3x3, stride-1 convolutional layer over a single tile of fixed-point feature data, producing one output feature map. A tile holds `N_CH` input channels of `ROWS` x `COLS` pixels. A start pulse opens a load phase, in which the tile is streamed word by word into on-chip buffers. The tile has to sit in local storage because every input value feeds up to nine output pixels. The engine then sweeps the output map in row-major order and streams results out on a valid/ready port.

For each output pixel and each of the nine kernel taps, one wide step reads all `N_CH` channels in the same cycle and forms their dot product against the tap's weights. The channel buffer is cut into `N_CH/2` banks, and each bank has two read ports. The multiplies, the channel adder tree and the tap accumulation are separate pipeline stages. A new channel dot product is accepted every clock, so with the output port ready a pixel leaves every nine clocks. Weights for one output map are written beforehand, while the engine is idle. Taps that fall outside the map read as zero, which gives a same-size output. Results saturate to the 16-bit data range.

Top module: `conv_dot_engine`

## Requirements
- R1: While `rst_ni` is low, `in_ready_o`, `out_valid_o` and `done_o` are all 0.
- R2: A `start_i` pulse while idle raises `in_ready_o` on the next cycle. Exactly `N_CH*ROWS*COLS` words are then accepted, pixel-major and channel-minor: word `p*N_CH + ch` is channel `ch` of pixel `p`, and pixel `p = row*COLS + col`. `in_ready_o` falls in the cycle after the last word is accepted.
- R3: Each output is the sum over channels `ch` and taps `t` of `w[ch*9 + t] * x[ch][row+dr][col+dc]`, with `t = (dr+1)*3 + (dc+1)` and `dr, dc` in -1..1. Weight address `ch*9 + t` is the `wgt_addr_i` value written.
- R4: A tap whose row or column falls outside the map contributes zero.
- R5: The sum is held in a 32-bit signed accumulator and saturates to the range -32768..32767 on output.
- R6: Exactly `ROWS*COLS` outputs leave per tile, in row-major pixel order.
- R7: With `out_ready_i` held high, the first output is valid 12 cycles after the clock edge that accepts the last input word, and each further output follows 9 cycles after the one before. This rate is one all-channel dot product per clock.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the whole pipeline stalls. `out_valid_o` stays high and `out_data_o` stays unchanged, and no result is lost.
- R9: `done_o` is high for exactly one cycle, the cycle after the edge that accepts the tile's last output.
- R10: `start_i` and weight writes have no effect unless the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tile (honoured only when idle) |
| wgt_we_i | input | 1 | Weight write strobe (honoured only when idle) |
| wgt_addr_i | input | $clog2(N_CH*9) | Weight address `ch*9 + tap` |
| wgt_data_i | input | DW | Signed weight value |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DW | Signed input word |
| in_ready_o | output | 1 | Engine takes input words (load phase) |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Consumer accepts output pixel |
| out_data_o | output | DW | Saturated signed output pixel |
| done_o | output | 1 | One-cycle pulse after the tile's last output is taken |

## Verification
The load port answers a start pulse one cycle later, and that cycle is checked. With the output port always ready, the first pixel is due exactly 12 cycles after the last input handshake and each next pixel 9 cycles later. The bench counts clock edges from that handshake and checks each output's arrival against that schedule. When the ready line is randomised, order and values are checked for every handshake, and the stall rule is checked on every cycle. The completion pulse is checked on every cycle against the single cycle that follows the last accepted pixel.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_COMP, ST_DRAIN} conv_state_e;
  localparam int TAPS = 9;
endpackage

// File: rtl/conv_in_bank.sv
// One channel-pair bank: single write port, two registered read ports.
module conv_in_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 60,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          en_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= '0;
      rdata_b_o <= '0;
    end else if (en_i) begin
      rdata_a_o <= mem[raddr_a_i];
      rdata_b_o <= mem[raddr_b_i];
    end
  end
endmodule

// File: rtl/conv_mac_tree.sv
// Unrolled channel multipliers, then a registered adder tree.
module conv_mac_tree #(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int SW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] px_i [N],
  input  logic signed [DW-1:0] wt_i [N],
  output logic signed [SW-1:0] sum_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod_q [N];
  logic signed [SW-1:0] tree;

  for (genvar i = 0; i < N; i++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   prod_q[i] <= '0;
      else if (en_i) prod_q[i] <= PW'(px_i[i]) * PW'(wt_i[i]);
    end
  end

  always_comb begin
    tree = '0;
    for (int i = 0; i < N; i++) tree = tree + SW'(prod_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= tree;
  end
endmodule

// File: rtl/conv_seq.sv
// Phase control: load counters, tap/pixel issue counters, output tally.
module conv_seq import conv_pkg::*; #(
  parameter int N_CH  = 4,
  parameter int ROWS  = 5,
  parameter int COLS  = 6,
  localparam int PIX   = ROWS * COLS,
  localparam int PIX_W = $clog2(PIX),
  localparam int CH_W  = $clog2(N_CH),
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic             en_i,
  input  logic             out_fire_i,
  output conv_state_e      state_o,
  output logic             in_ready_o,
  output logic             ld_we_o,
  output logic [PIX_W-1:0] ld_pix_o,
  output logic [CH_W-1:0]  ld_ch_o,
  output logic             iss_vld_o,
  output logic [ROW_W-1:0] iss_row_o,
  output logic [COL_W-1:0] iss_col_o,
  output logic [3:0]       iss_tap_o,
  output logic             done_o
);
  conv_state_e      state_q;
  logic [PIX_W-1:0] out_cnt_q;
  logic ld_fire, ld_last, iss_step, iss_last, out_last;

  assign in_ready_o = (state_q == ST_LOAD);
  assign ld_fire    = in_valid_i && in_ready_o;
  assign ld_we_o    = ld_fire;
  assign ld_last    = ld_fire && ld_ch_o == CH_W'(N_CH - 1) && ld_pix_o == PIX_W'(PIX - 1);
  assign iss_vld_o  = (state_q == ST_COMP);
  assign iss_step   = iss_vld_o && en_i;
  assign iss_last   = iss_step && iss_tap_o == 4'd8 &&
                      iss_row_o == ROW_W'(ROWS - 1) && iss_col_o == COL_W'(COLS - 1);
  assign out_last   = out_fire_i && out_cnt_q == PIX_W'(PIX - 1);
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ld_pix_o  <= '0;
      ld_ch_o   <= '0;
      iss_row_o <= '0;
      iss_col_o <= '0;
      iss_tap_o <= '0;
      out_cnt_q <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_LOAD;
          ld_pix_o <= '0;
          ld_ch_o  <= '0;
        end
        ST_LOAD: if (ld_fire) begin
          if (ld_ch_o == CH_W'(N_CH - 1)) begin
            ld_ch_o  <= '0;
            ld_pix_o <= ld_pix_o + 1'b1;
          end else begin
            ld_ch_o  <= ld_ch_o + 1'b1;
          end
          if (ld_last) begin
            state_q   <= ST_COMP;
            iss_row_o <= '0;
            iss_col_o <= '0;
            iss_tap_o <= '0;
            out_cnt_q <= '0;
          end
        end
        ST_COMP: if (iss_step) begin
          if (iss_tap_o == 4'd8) begin
            iss_tap_o <= '0;
            if (iss_col_o == COL_W'(COLS - 1)) begin
              iss_col_o <= '0;
              iss_row_o <= iss_row_o + 1'b1;
            end else begin
              iss_col_o <= iss_col_o + 1'b1;
            end
          end else begin
            iss_tap_o <= iss_tap_o + 1'b1;
          end
          if (iss_last) state_q <= ST_DRAIN;
        end
        default: ;
      endcase
      if (out_fire_i) out_cnt_q <= out_cnt_q + 1'b1;
      if (out_last) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_dot_engine.sv
module conv_dot_engine import conv_pkg::*; #(
  parameter int N_CH  = 4,
  parameter int ROWS  = 5,
  parameter int COLS  = 6,
  parameter int DW    = 16,
  parameter int ACC_W = 32,
  localparam int WA_W = $clog2(N_CH * TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            wgt_we_i,
  input  logic [WA_W-1:0] wgt_addr_i,
  input  logic [DW-1:0]   wgt_data_i,
  input  logic            in_valid_i,
  input  logic [DW-1:0]   in_data_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [DW-1:0]   out_data_o,
  output logic            done_o
);
  localparam int PIX   = ROWS * COLS;
  localparam int PIX_W = $clog2(PIX);
  localparam int CH_W  = $clog2(N_CH);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int NB    = N_CH / 2;
  localparam int NW    = N_CH * TAPS;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (DW - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  conv_state_e      state;
  logic             en, out_fire;
  logic             ld_we;
  logic [PIX_W-1:0] ld_pix;
  logic [CH_W-1:0]  ld_ch;
  logic             iss_vld;
  logic [ROW_W-1:0] iss_row;
  logic [COL_W-1:0] iss_col;
  logic [3:0]       iss_tap;

  // whole pipeline advances only when the output slot is free or draining
  assign en       = !out_valid_o || out_ready_i;
  assign out_fire = out_valid_o && out_ready_i;

  conv_seq #(.N_CH(N_CH), .ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk_i, .rst_ni, .start_i, .in_valid_i,
    .en_i(en), .out_fire_i(out_fire),
    .state_o(state), .in_ready_o,
    .ld_we_o(ld_we), .ld_pix_o(ld_pix), .ld_ch_o(ld_ch),
    .iss_vld_o(iss_vld), .iss_row_o(iss_row), .iss_col_o(iss_col), .iss_tap_o(iss_tap),
    .done_o
  );

  // weight store, writable only when idle
  logic signed [DW-1:0] wgt_q [NW];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) wgt_q[i] <= '0;
    end else if (wgt_we_i && state == ST_IDLE && int'(wgt_addr_i) < NW) begin
      wgt_q[wgt_addr_i] <= wgt_data_i;
    end
  end

  // stage 0: tap address and edge padding
  int               rr, cc;
  logic             pad0;
  logic [PIX_W-1:0] rd_pix;
  always_comb begin
    rr     = int'(iss_row) + int'(iss_tap) / 3 - 1;
    cc     = int'(iss_col) + int'(iss_tap) % 3 - 1;
    pad0   = (rr < 0) || (rr >= ROWS) || (cc < 0) || (cc >= COLS);
    rd_pix = pad0 ? '0 : PIX_W'(rr * COLS + cc);
  end

  // stage 1: banked read, N_CH values per cycle
  logic [DW-1:0] rd_a [NB];
  logic [DW-1:0] rd_b [NB];
  for (genvar b = 0; b < NB; b++) begin : g_bank
    conv_in_bank #(.DW(DW), .DEPTH(2 * PIX)) u_bank (
      .clk_i, .rst_ni,
      .we_i     (ld_we && (ld_ch >> 1) == CH_W'(b)),
      .waddr_i  ({ld_pix, ld_ch[0]}),
      .wdata_i  (in_data_i),
      .en_i     (en),
      .raddr_a_i({rd_pix, 1'b0}),
      .raddr_b_i({rd_pix, 1'b1}),
      .rdata_a_o(rd_a[b]),
      .rdata_b_o(rd_b[b])
    );
  end

  logic       s1_vld, s1_pad, s1_first, s1_last;
  logic [3:0] s1_tap;
  logic       s2_vld, s2_first, s2_last;
  logic       s3_vld, s3_first, s3_last;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {s1_vld, s1_pad, s1_first, s1_last} <= '0;
      s1_tap <= '0;
      {s2_vld, s2_first, s2_last} <= '0;
      {s3_vld, s3_first, s3_last} <= '0;
    end else if (en) begin
      s1_vld   <= iss_vld;
      s1_pad   <= pad0;
      s1_first <= (iss_tap == 4'd0);
      s1_last  <= (iss_tap == 4'd8);
      s1_tap   <= iss_tap;
      {s2_vld, s2_first, s2_last} <= {s1_vld, s1_first, s1_last};
      {s3_vld, s3_first, s3_last} <= {s2_vld, s2_first, s2_last};
    end
  end

  logic signed [DW-1:0] px   [N_CH];
  logic signed [DW-1:0] wsel [N_CH];
  always_comb begin
    for (int ch = 0; ch < N_CH; ch++) begin
      px[ch]   = s1_pad ? '0 : ((ch % 2 == 0) ? rd_a[ch / 2] : rd_b[ch / 2]);
      wsel[ch] = wgt_q[ch * TAPS + int'(s1_tap)];
    end
  end

  // stages 2-3: multipliers and channel adder tree
  logic signed [ACC_W-1:0] sum3;
  conv_mac_tree #(.N(N_CH), .DW(DW), .SW(ACC_W)) u_mac (
    .clk_i, .rst_ni, .en_i(en), .px_i(px), .wt_i(wsel), .sum_o(sum3)
  );

  // stage 4: tap accumulation and saturation
  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic        [DW-1:0]    sat_v;
  always_comb begin
    acc_nx = (s3_first ? '0 : acc_q) + sum3;
    if (acc_nx > SAT_HI)      sat_v = SAT_HI[DW-1:0];
    else if (acc_nx < SAT_LO) sat_v = SAT_LO[DW-1:0];
    else                      sat_v = acc_nx[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (en) begin
      if (s3_vld) acc_q <= acc_nx;
      out_valid_o <= s3_vld && s3_last;
      if (s3_vld && s3_last) out_data_o <= sat_v;
    end
  end
endmodule

// File: rtl/conv_dot_engine_chk.sv
module conv_dot_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          done_o
);
  // R8: stalled output holds valid and data
  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R9: completion follows an accepted output
  a_r9_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o && out_ready_i));

  // R9: single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2: loading and producing never overlap
  a_r2_load_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o);

  // R2: no completion while loading
  a_r2_load_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !done_o);
endmodule

bind conv_dot_engine conv_dot_engine_chk #(.DW(DW)) u_chk (.*);

// File: tb/conv_dot_engine_test.sv
module conv_dot_engine_test;
  localparam int N_CH = 4, ROWS = 5, COLS = 6, DW = 16;
  localparam int PIX = ROWS * COLS, NW = N_CH * 9;

  logic clk_i = 0, rst_ni = 0, start_i = 0, wgt_we_i = 0, in_valid_i = 0, out_ready_i = 0;
  logic [5:0]    wgt_addr_i = '0;
  logic [DW-1:0] wgt_data_i = '0, in_data_i = '0;
  logic          in_ready_o, out_valid_o, done_o;
  logic [DW-1:0] out_data_o;

  conv_dot_engine #(.N_CH(N_CH), .ROWS(ROWS), .COLS(COLS), .DW(DW)) uut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  int img [N_CH][PIX];
  int wt  [NW];
  int expv [PIX];
  int idx = 0, load_end = 0;
  bit rdy_rand = 0, timing_on = 0, edge_tags = 0, done_due = 0, tile_done = 0;
  bit prev_v = 0, prev_r = 0;
  logic [DW-1:0] prev_d = '0;
  string tag = "R3";

  always @(posedge clk_i) cyc++;

  task automatic check(input bit ok, input string req, input string what, input int got, input int ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, ex);
    end
  endtask

  function automatic bit on_edge(input int p);
    return (p / COLS == 0) || (p / COLS == ROWS - 1) || (p % COLS == 0) || (p % COLS == COLS - 1);
  endfunction

  task automatic build_expected();
    for (int p = 0; p < PIX; p++) begin
      int acc = 0;
      for (int ch = 0; ch < N_CH; ch++)
        for (int t = 0; t < 9; t++) begin
          int r2 = p / COLS + t / 3 - 1;
          int c2 = p % COLS + t % 3 - 1;
          if (r2 >= 0 && r2 < ROWS && c2 >= 0 && c2 < COLS)
            acc += wt[ch * 9 + t] * img[ch][r2 * COLS + c2];
        end
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      expv[p] = acc;
    end
  endtask

  // output monitor and reference comparison, every clock
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_v && !prev_r) begin
        check(out_valid_o == 1'b1, "R8", "valid held under stall", int'(out_valid_o), 1);
        check(out_data_o == prev_d, "R8", "data held under stall",
              int'($signed(out_data_o)), int'($signed(prev_d)));
      end
      check(done_o == done_due, "R9", "done pulse", int'(done_o), int'(done_due));
      if (done_due) tile_done = 1;
      done_due = 0;
      out_ready_i = rdy_rand ? ($urandom % 10 < 6) : 1'b1;
      if (out_valid_o && out_ready_i) begin
        if (idx < PIX) begin
          string rq = (edge_tags && on_edge(idx)) ? "R4" : tag;
          check(int'($signed(out_data_o)) == expv[idx], rq, $sformatf("pixel %0d value", idx),
                int'($signed(out_data_o)), expv[idx]);
          if (timing_on)
            check(cyc == load_end + 12 + 9 * idx, "R7", $sformatf("pixel %0d arrival cycle", idx),
                  cyc - load_end, 12 + 9 * idx);
        end else begin
          check(1'b0, "R6", "extra output pixel", idx + 1, PIX);
        end
        idx++;
        if (idx == PIX) done_due = 1;
      end
      prev_v = out_valid_o;
      prev_r = out_ready_i;
      prev_d = out_data_o;
    end
  end

  task automatic load_weights();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk_i);
      wgt_we_i = 1; wgt_addr_i = 6'(i); wgt_data_i = DW'(wt[i]);
    end
    @(negedge clk_i);
    wgt_we_i = 0;
  endtask

  task automatic run_tile(input bit bubbles, input bit meddle);
    int w = 0;
    build_expected();
    idx = 0; tile_done = 0;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    check(in_ready_o == 1'b1, "R2", "ready after start", int'(in_ready_o), 1);
    while (w < N_CH * PIX) begin
      if (w > 0) @(negedge clk_i);
      if (bubbles && ($urandom % 4 == 0)) begin
        in_valid_i = 0;
      end else begin
        in_valid_i = 1;
        in_data_i = DW'(img[w % N_CH][w / N_CH]);
        if (in_ready_o) begin
          if (w == N_CH * PIX - 1) load_end = cyc + 1;
          w++;
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 0;
    check(in_ready_o == 1'b0, "R2", "ready falls after last word", int'(in_ready_o), 0);
    if (meddle) begin
      repeat (5) @(negedge clk_i);
      start_i = 1; wgt_we_i = 1; wgt_addr_i = 6'd0; wgt_data_i = 16'd77;
      @(negedge clk_i);
      start_i = 0; wgt_we_i = 0;
      repeat (3) begin
        @(negedge clk_i);
        check(in_ready_o == 1'b0, "R10", "start ignored while busy", int'(in_ready_o), 0);
      end
    end
    while (!tile_done) @(negedge clk_i);
    check(idx == PIX, "R6", "pixels per tile", idx, PIX);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1", "out_valid in reset", int'(out_valid_o), 0);
    check(in_ready_o == 1'b0, "R1", "in_ready in reset", int'(in_ready_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    rst_ni = 1;

    // tile A: ordinary values, ready always high, exact timing
    for (int i = 0; i < NW; i++) wt[i] = int'($urandom % 17) - 8;
    for (int ch = 0; ch < N_CH; ch++)
      for (int p = 0; p < PIX; p++) img[ch][p] = int'($urandom % 201) - 100;
    load_weights();
    tag = "R3"; edge_tags = 1; timing_on = 1; rdy_rand = 0;
    run_tile(0, 0);

    // tile B: new data, stalls, input bubbles, writes and start while busy
    for (int ch = 0; ch < N_CH; ch++)
      for (int p = 0; p < PIX; p++) img[ch][p] = int'($urandom % 401) - 200;
    tag = "R10"; edge_tags = 0; timing_on = 0; rdy_rand = 1;
    run_tile(1, 1);

    // tile C: positive saturation
    for (int i = 0; i < NW; i++) wt[i] = 1000;
    for (int ch = 0; ch < N_CH; ch++)
      for (int p = 0; p < PIX; p++) img[ch][p] = 1000;
    load_weights();
    tag = "R5"; rdy_rand = 0;
    run_tile(0, 0);

    // tile D: negative saturation under stalls
    for (int i = 0; i < NW; i++) wt[i] = -1000;
    load_weights();
    tag = "R5"; rdy_rand = 1;
    run_tile(0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R9 watchdog expired, tile incomplete got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule